// File: doc/BRIEF.md
# Microwire Serial EEPROM Front End

This block sits between the four serial pins of a small three-wire EEPROM model and the storage behind it. It runs on a fast system clock and samples chip select, serial clock and data-in as ordinary synchronous inputs. It finds the start of each instruction and collects the opcode and address, then sorts the frame into one of seven commands. Reads are streamed back out on data-out. Program and erase commands become a single-cycle request to a separate cycle controller, which owns the non-volatile timing.

An organisation input picks byte or word mode. A read fetches from a synchronous register-file port with one cycle of latency. The next location is prefetched while the current one is shifted out, so a reader can hold select high and clock through the whole array without a gap. Power-on is modelled by the active-low reset, and that reset also clears the erase/write enable latch.

Top module: `mw_eeprom_frontend`

## Requirements
- R1: A frame is armed only when select rises while the serial clock is low. In an armed frame, data-in is sampled on each rising serial clock edge, and zeros are skipped until the first 1, which is the start bit. If select rises while the serial clock is high, nothing in that selection is acted on.
- R2: The two bits after the start bit are the opcode: 10 is read, 01 is write and 11 is erase. Opcode 00 is resolved by the two most significant address bits: 11 enables erase/write, 00 disables it, 10 is erase-all and 01 is write-all.
- R3: With `org_i` high, the block works in 16-bit words with 6 address bits. With it low, it works in 8-bit bytes with 7 address bits. In byte mode the data sits in bits 7:0 of data buses.
- R4: After the last address bit of a read, `do_o` drives a single 0 dummy bit. The addressed unit then follows MSB first, with each bit changing only after a rising serial clock edge.
- R5: While select stays high, a read continues with the next address and no dummy bit. After the top location (63 in word mode, 127 in byte mode) it wraps to 0.
- R6: The erase/write enable latch is clear after reset. The enable command sets it and the disable command clears it. Reads behave the same whatever its state.
- R7: For write and write-all, 16 or 8 data bits follow the address, so a word write is 25 serial clocks in total. The request is issued only when select falls with no further rising serial clock edge after the last data bit. One extra edge cancels it.
- R8: When the latch is clear, write, erase, erase-all and write-all issue no request.
- R9: A request is a one-cycle `req_valid_o` pulse with `req_op_o` set to 0 (write), 1 (erase), 2 (erase-all) or 3 (write-all), plus the address and data. Erase and erase-all are issued when select falls after the last address bit.
- R10: While select is low, `do_oe_o` is low. Dropping select aborts any frame, and a frame cut short issues nothing.
- R11: A read fetch is a one-cycle `mem_rd_o` pulse with `mem_addr_o`, and `mem_rdata_i` is taken on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, models power-on |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | 1 = word mode, 0 = byte mode |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for data out |
| mem_rd_o | output | 1 | Read strobe to the array |
| mem_addr_o | output | 7 | Unit address of the fetch |
| mem_rdata_i | input | 16 | Array read data, one cycle after the strobe |
| req_valid_o | output | 1 | Program/erase request pulse |
| req_op_o | output | 2 | Request kind |
| req_addr_o | output | 7 | Request address |
| req_data_o | output | 16 | Request data |

## Verification
The assertions assume that `org_i` is steady for the whole of a selection. They also assume that each serial clock level lasts long enough for a read prefetch to land, which is at least three system clocks, before the next rising edge. The stimulus changes the organisation only while select is low. It holds each serial clock phase for four system clocks and drives every pin on the falling system clock edge, so the synchroniser always sees a clean level.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_RD,
        ST_HOLD,
        ST_SPENT
    } mw_state_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_ERAL,
        CMD_WRAL,
        CMD_EWEN,
        CMD_EWDS
    } mw_cmd_e;

    typedef enum logic [1:0] {
        REQ_WRITE = 2'd0,
        REQ_ERASE = 2'd1,
        REQ_ERAL  = 2'd2,
        REQ_WRAL  = 2'd3
    } mw_req_e;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_o,
    output logic sk_o,
    output logic di_o,
    output logic cs_rise_o,
    output logic sk_rise_o
);

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
        logic cs_p;
        logic sk_p;
    } pins_t;

    pins_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.cs   = cs_i;
        r_d.sk   = sk_i;
        r_d.di   = di_i;
        r_d.cs_p = r_q.cs;
        r_d.sk_p = r_q.sk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_o      = r_q.cs;
    assign sk_o      = r_q.sk;
    assign di_o      = r_q.di;
    assign cs_rise_o = r_q.cs & ~r_q.cs_p;
    assign sk_rise_o = r_q.sk & ~r_q.sk_p;

    // A sampled rising edge means the previous sample was low (R1).
    p_sk_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sk_rise_o |=> !sk_rise_o);

endmodule

// File: rtl/mw_cmd_decode.sv
module mw_cmd_decode
    import mw_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic [1:0] top_word_i,
    input  logic [1:0] top_byte_i,
    input  logic       byte_mode_i,
    output mw_cmd_e    cmd_o
);

    logic [1:0] sel;

    always_comb begin
        sel = byte_mode_i ? top_byte_i : top_word_i;
        unique case (op_i)
            2'b10: cmd_o = CMD_READ;
            2'b01: cmd_o = CMD_WRITE;
            2'b11: cmd_o = CMD_ERASE;
            default: begin
                unique case (sel)
                    2'b11:   cmd_o = CMD_EWEN;
                    2'b00:   cmd_o = CMD_EWDS;
                    2'b10:   cmd_o = CMD_ERAL;
                    default: cmd_o = CMD_WRAL;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/mw_read_path.sv
module mw_read_path #(
    parameter int WORD_ADDR_W = 6,
    parameter int WORD_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_mode_i,
    input  logic                   abort_i,
    input  logic                   start_i,
    input  logic [WORD_ADDR_W:0]   start_addr_i,
    input  logic                   step_i,
    output logic                   mem_rd_o,
    output logic [WORD_ADDR_W:0]   mem_addr_o,
    input  logic [WORD_W-1:0]      mem_rdata_i,
    output logic                   do_o
);

    localparam int BYTE_ADDR_W = WORD_ADDR_W + 1;
    localparam int BYTE_W      = WORD_W / 2;
    localparam int CNT_W       = $clog2(WORD_W);

    typedef struct packed {
        logic [BYTE_ADDR_W-1:0] addr;
        logic                   fetch;
        logic                   catch_;
        logic [WORD_W-1:0]      nxt;
        logic [WORD_W-1:0]      sh;
        logic [CNT_W-1:0]       cnt;
        logic                   dout;
    } rd_t;

    rd_t r_q, r_d;
    logic [WORD_W-1:0]      word_al;
    logic [BYTE_ADDR_W-1:0] addr_inc;

    always_comb begin
        r_d        = r_q;
        r_d.fetch  = 1'b0;
        r_d.catch_ = r_q.fetch;
        word_al    = byte_mode_i ? {r_q.nxt[BYTE_W-1:0], {BYTE_W{1'b0}}} : r_q.nxt;
        addr_inc   = r_q.addr + 1'b1;
        if (!byte_mode_i) begin
            addr_inc[BYTE_ADDR_W-1] = 1'b0;
        end
        if (r_q.catch_) begin
            r_d.nxt = mem_rdata_i;
        end
        if (abort_i) begin
            r_d.cnt   = '0;
            r_d.dout  = 1'b0;
            r_d.fetch = 1'b0;
        end else if (start_i) begin
            r_d.addr  = start_addr_i;
            r_d.fetch = 1'b1;
            r_d.cnt   = '0;
            r_d.dout  = 1'b0;
        end else if (step_i) begin
            if (r_q.cnt == '0) begin
                r_d.dout  = word_al[WORD_W-1];
                r_d.sh    = word_al << 1;
                r_d.cnt   = byte_mode_i ? CNT_W'(BYTE_W - 1) : CNT_W'(WORD_W - 1);
                r_d.addr  = addr_inc;
                r_d.fetch = 1'b1;
            end else begin
                r_d.dout = r_q.sh[WORD_W-1];
                r_d.sh   = r_q.sh << 1;
                r_d.cnt  = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_o   = r_q.fetch;
    assign mem_addr_o = r_q.addr;
    assign do_o       = r_q.dout;

    // Dummy bit is 0 and the bit counter is at a unit boundary (R4).
    p_dummy_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i) |=> (do_o == 1'b0 && r_q.cnt == '0));

    // Fetch strobe is a single cycle (R11).
    p_fetch_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    // In word mode the address stays inside the 6-bit space (R5).
    p_word_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !byte_mode_i) |-> !r_q.addr[BYTE_ADDR_W-1]);

endmodule

// File: rtl/mw_eeprom_frontend.sv
module mw_eeprom_frontend
    import mw_pkg::*;
#(
    parameter int WORD_ADDR_W = 6,
    parameter int WORD_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_i,
    input  logic                   sk_i,
    input  logic                   di_i,
    input  logic                   org_i,
    output logic                   do_o,
    output logic                   do_oe_o,
    output logic                   mem_rd_o,
    output logic [WORD_ADDR_W:0]   mem_addr_o,
    input  logic [WORD_W-1:0]      mem_rdata_i,
    output logic                   req_valid_o,
    output logic [1:0]             req_op_o,
    output logic [WORD_ADDR_W:0]   req_addr_o,
    output logic [WORD_W-1:0]      req_data_o
);

    localparam int BYTE_ADDR_W = WORD_ADDR_W + 1;
    localparam int BYTE_W      = WORD_W / 2;
    localparam int CNT_W       = $clog2(WORD_W);

    typedef struct packed {
        mw_state_e              st;
        logic [1:0]             op;
        logic [BYTE_ADDR_W-1:0] adr;
        logic [WORD_W-1:0]      dat;
        logic [CNT_W-1:0]       cnt;
        logic                   wen;
        mw_req_e                pkind;
        logic                   rq_v;
        mw_req_e                rq_op;
        logic [BYTE_ADDR_W-1:0] rq_adr;
        logic [WORD_W-1:0]      rq_dat;
    } fe_t;

    fe_t r_q, r_d;

    logic cs_s, sk_s, di_s, cs_rise, sk_rise;
    logic byte_mode;
    logic [BYTE_ADDR_W-1:0] adr_n;
    logic [CNT_W-1:0] alen_m1, dlen_m1;
    mw_cmd_e cmd;
    logic rd_start;
    logic rd_do;

    mw_pin_sync u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs_i),
        .sk_i      (sk_i),
        .di_i      (di_i),
        .cs_o      (cs_s),
        .sk_o      (sk_s),
        .di_o      (di_s),
        .cs_rise_o (cs_rise),
        .sk_rise_o (sk_rise)
    );

    assign byte_mode = ~org_i;
    assign adr_n     = {r_q.adr[BYTE_ADDR_W-2:0], di_s};
    assign alen_m1   = byte_mode ? CNT_W'(BYTE_ADDR_W - 1) : CNT_W'(WORD_ADDR_W - 1);
    assign dlen_m1   = byte_mode ? CNT_W'(BYTE_W - 1) : CNT_W'(WORD_W - 1);

    mw_cmd_decode u_dec (
        .op_i        (r_q.op),
        .top_word_i  (adr_n[WORD_ADDR_W-1 -: 2]),
        .top_byte_i  (adr_n[BYTE_ADDR_W-1 -: 2]),
        .byte_mode_i (byte_mode),
        .cmd_o       (cmd)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rq_v = 1'b0;
        rd_start = 1'b0;
        if (!cs_s) begin
            if (r_q.st == ST_HOLD && r_q.wen) begin
                r_d.rq_v   = 1'b1;
                r_d.rq_op  = r_q.pkind;
                r_d.rq_adr = r_q.adr;
                r_d.rq_dat = r_q.dat;
            end
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (cs_rise) begin
                        r_d.st = sk_s ? ST_SPENT : ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (sk_rise && di_s) begin
                        r_d.st  = ST_OPC;
                        r_d.cnt = '0;
                        r_d.op  = '0;
                        r_d.adr = '0;
                        r_d.dat = '0;
                    end
                end
                ST_OPC: begin
                    if (sk_rise) begin
                        r_d.op = {r_q.op[0], di_s};
                        if (r_q.cnt == CNT_W'(1)) begin
                            r_d.st  = ST_ADR;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_ADR: begin
                    if (sk_rise) begin
                        r_d.adr = adr_n;
                        if (r_q.cnt == alen_m1) begin
                            r_d.cnt = '0;
                            unique case (cmd)
                                CMD_READ: begin
                                    r_d.st   = ST_RD;
                                    rd_start = 1'b1;
                                end
                                CMD_WRITE: begin
                                    r_d.st    = ST_DAT;
                                    r_d.pkind = REQ_WRITE;
                                end
                                CMD_WRAL: begin
                                    r_d.st    = ST_DAT;
                                    r_d.pkind = REQ_WRAL;
                                end
                                CMD_ERASE: begin
                                    r_d.st    = ST_HOLD;
                                    r_d.pkind = REQ_ERASE;
                                end
                                CMD_ERAL: begin
                                    r_d.st    = ST_HOLD;
                                    r_d.pkind = REQ_ERAL;
                                end
                                CMD_EWEN: begin
                                    r_d.st  = ST_SPENT;
                                    r_d.wen = 1'b1;
                                end
                                CMD_EWDS: begin
                                    r_d.st  = ST_SPENT;
                                    r_d.wen = 1'b0;
                                end
                                default: r_d.st = ST_SPENT;
                            endcase
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DAT: begin
                    if (sk_rise) begin
                        r_d.dat = {r_q.dat[WORD_W-2:0], di_s};
                        if (r_q.cnt == dlen_m1) begin
                            r_d.st = ST_HOLD;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (sk_rise) begin
                        r_d.st = ST_SPENT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.op     <= '0;
            r_q.adr    <= '0;
            r_q.dat    <= '0;
            r_q.cnt    <= '0;
            r_q.wen    <= 1'b0;
            r_q.pkind  <= REQ_WRITE;
            r_q.rq_v   <= 1'b0;
            r_q.rq_op  <= REQ_WRITE;
            r_q.rq_adr <= '0;
            r_q.rq_dat <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    mw_read_path #(
        .WORD_ADDR_W (WORD_ADDR_W),
        .WORD_W      (WORD_W)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_mode_i  (byte_mode),
        .abort_i      (~cs_s),
        .start_i      (rd_start),
        .start_addr_i (adr_n),
        .step_i       (sk_rise && r_q.st == ST_RD),
        .mem_rd_o     (mem_rd_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rdata_i  (mem_rdata_i),
        .do_o         (rd_do)
    );

    assign do_o        = rd_do;
    assign do_oe_o     = cs_s;
    assign req_valid_o = r_q.rq_v;
    assign req_op_o    = r_q.rq_op;
    assign req_addr_o  = r_q.rq_adr;
    assign req_data_o  = r_q.rq_dat;

    // No request leaves while the enable latch is clear (R8).
    p_req_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> r_q.wen);

    // A request is a single-cycle pulse (R9).
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

    // Deselect returns the frame logic to idle (R10).
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (r_q.st == ST_IDLE));

    // A read is only ever started with select asserted (R4).
    p_read_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> do_oe_o);

endmodule

// File: tb/tb_mw_eeprom_frontend.sv
`timescale 1ns/1ps
module tb_mw_eeprom_frontend;

    localparam int HALF = 4;
    localparam int NV   = 6;
    localparam logic V_ORG [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int   V_ADR [NV] = '{5, 63, 17, 127, 0, 64};
    localparam int   V_CNT [NV] = '{1, 2, 2, 3, 3, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_i = 1'b0, sk_i = 1'b0, di_i = 1'b0, org_i = 1'b1;
    logic do_o, do_oe_o, mem_rd_o, req_valid_o;
    logic [6:0] mem_addr_o, req_addr_o;
    logic [15:0] mem_rdata_i = '0, req_data_o;
    logic [1:0] req_op_o;

    int total = 0, bad = 0, req_cnt = 0, pulses = 0;
    logic [1:0] last_op;
    logic [6:0] last_adr;
    logic [15:0] last_dat;

    always #2.5 clk = ~clk;

    mw_eeprom_frontend dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i), .org_i(org_i),
        .do_o(do_o), .do_oe_o(do_oe_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .req_valid_o(req_valid_o), .req_op_o(req_op_o),
        .req_addr_o(req_addr_o), .req_data_o(req_data_o)
    );

    function automatic logic [15:0] memval(input int a);
        return 16'(a * 291 + 39516);
    endfunction

    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= memval(int'(mem_addr_o));

    always @(negedge clk) if (req_valid_o) begin
        req_cnt++;
        last_op  = req_op_o;
        last_adr = req_addr_o;
        last_dat = req_data_o;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b, output logic q);
        di_i = b;
        tick(HALF);
        sk_i = 1'b1;
        pulses++;
        tick(HALF);
        q = do_o;
        sk_i = 1'b0;
    endtask

    task automatic send(input int val, input int n);
        logic q;
        for (int i = n - 1; i >= 0; i--) pulse(val[i], q);
    endtask

    task automatic select();
        sk_i = 1'b0;
        tick(2);
        cs_i = 1'b1;
        pulses = 0;
        tick(HALF);
    endtask

    task automatic deselect();
        tick(2);
        cs_i = 1'b0;
        tick(6);
    endtask

    // op: 2-bit opcode, adr: address field, data sent when nd > 0
    task automatic frame(input logic org, input int op, input int adr, input int dat,
                         input bit with_data, input bit extra);
        logic q;
        org_i = org;
        select();
        send(1, 1);
        send(op, 2);
        send(adr, org ? 6 : 7);
        if (with_data) send(dat, org ? 16 : 8);
        if (extra) pulse(1'b0, q);
        deselect();
    endtask

    task automatic rd_frame(input logic org, input int adr, input int nw, input int lead, input string tag);
        logic q;
        logic [15:0] got, exp;
        int a, alen, dlen;
        org_i = org;
        alen = org ? 6 : 7;
        dlen = org ? 16 : 8;
        select();
        send(0, lead);
        pulse(1'b1, q);
        pulse(1'b1, q);
        pulse(1'b0, q);
        for (int i = alen - 1; i >= 0; i--) pulse(adr[i], q);
        check({tag, " R4 dummy bit"}, 32'(q), 32'(0));
        a = adr;
        for (int w = 0; w < nw; w++) begin
            got = '0;
            for (int i = 0; i < dlen; i++) begin
                pulse(1'b0, q);
                got = {got[14:0], q};
            end
            exp = org ? memval(a) : {8'h00, memval(a)[7:0]};
            check($sformatf("%s R5 R3 unit %0d addr %0d", tag, w, a), 32'(got), 32'(exp));
            a = (a + 1) % (org ? 64 : 128);
        end
        deselect();
        check({tag, " R10 oe low"}, 32'(do_oe_o), 32'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int exp_req;
        tick(5);
        check("R10 reset oe", 32'(do_oe_o), 32'(0));
        check("R4 reset do", 32'(do_o), 32'(0));
        check("R9 reset req", 32'(req_valid_o), 32'(0));
        rst_n = 1'b1;
        tick(4);

        // Read vectors, latch still clear (R6 reads unaffected, R11 fetch path)
        for (int v = 0; v < NV; v++)
            rd_frame(V_ORG[v], V_ADR[v], V_CNT[v], 0, $sformatf("R6 R11 vec%0d", v));

        exp_req = 0;
        // R8: write with latch clear
        frame(1'b1, 2'b01, 6'h15, 16'hBEEF, 1'b1, 1'b0);
        check("R8 no request while disabled", 32'(req_cnt), 32'(exp_req));

        // R6 R2: enable, 00 + 11xxxx
        frame(1'b1, 2'b00, 6'h30, 0, 1'b0, 1'b0);
        frame(1'b1, 2'b01, 6'h15, 16'hBEEF, 1'b1, 1'b0);
        exp_req++;
        check("R7 word write pulses", 32'(pulses), 32'(25));
        check("R7 write request", 32'(req_cnt), 32'(exp_req));
        check("R9 write op", 32'(last_op), 32'(0));
        check("R9 write addr", 32'(last_adr), 32'(7'h15));
        check("R9 write data", 32'(last_dat), 32'(16'hBEEF));

        // R3 byte-mode write
        frame(1'b0, 2'b01, 7'h55, 8'hA7, 1'b1, 1'b0);
        exp_req++;
        check("R3 byte write request", 32'(req_cnt), 32'(exp_req));
        check("R3 byte write addr", 32'(last_adr), 32'(7'h55));
        check("R3 byte write data", 32'(last_dat), 32'(16'h00A7));

        // R7 extra clock cancels
        frame(1'b1, 2'b01, 6'h02, 16'h1111, 1'b1, 1'b1);
        check("R7 late deselect cancels", 32'(req_cnt), 32'(exp_req));

        // R2 R9 erase
        frame(1'b1, 2'b11, 6'h2A, 0, 1'b0, 1'b0);
        exp_req++;
        check("R9 erase request", 32'(req_cnt), 32'(exp_req));
        check("R2 erase op", 32'(last_op), 32'(1));
        check("R9 erase addr", 32'(last_adr), 32'(7'h2A));

        // R2 erase-all, word mode
        frame(1'b1, 2'b00, 6'h20, 0, 1'b0, 1'b0);
        exp_req++;
        check("R2 erase-all request", 32'(req_cnt), 32'(exp_req));
        check("R2 erase-all op", 32'(last_op), 32'(2));

        // R2 write-all
        frame(1'b1, 2'b00, 6'h10, 16'h1234, 1'b1, 1'b0);
        exp_req++;
        check("R2 write-all request", 32'(req_cnt), 32'(exp_req));
        check("R2 write-all op", 32'(last_op), 32'(3));
        check("R2 write-all data", 32'(last_dat), 32'(16'h1234));

        // R3 byte mode: top two of 7 address bits select erase-all
        frame(1'b0, 2'b00, 7'h40, 0, 1'b0, 1'b0);
        exp_req++;
        check("R3 byte erase-all request", 32'(req_cnt), 32'(exp_req));
        check("R3 byte erase-all op", 32'(last_op), 32'(2));

        // R10 abort mid-data
        org_i = 1'b1;
        select();
        send(1, 1); send(2'b01, 2); send(6'h07, 6); send(16'hFF, 8);
        deselect();
        check("R10 aborted write silent", 32'(req_cnt), 32'(exp_req));

        // R1 select rising while clock high
        org_i = 1'b1;
        sk_i = 1'b1;
        tick(2);
        cs_i = 1'b1;
        tick(HALF);
        sk_i = 1'b0;
        send(1, 1); send(2'b11, 2); send(6'h01, 6);
        deselect();
        check("R1 unarmed frame silent", 32'(req_cnt), 32'(exp_req));

        // R1 leading zeros before the start bit
        rd_frame(1'b1, 9, 1, 3, "R1 leading zeros");

        // R6 disable then erase is refused, reads still work
        frame(1'b1, 2'b00, 6'h00, 0, 1'b0, 1'b0);
        frame(1'b1, 2'b11, 6'h2A, 0, 1'b0, 1'b0);
        check("R6 disabled erase silent", 32'(req_cnt), 32'(exp_req));
        rd_frame(1'b0, 126, 2, 0, "R6 read after disable");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule